// File: doc/BRIEF.md
# Streaming RGB-to-Luma Converter

This block turns a stream of packed 8-bit RGB pixels into 8-bit luma values with Rec.709 weighting, sixteen pixels at a time. Input words are 128 bits wide. Each pixel takes three consecutive bytes (red, then green, then blue), so a pixel may straddle two input words. The block gathers a group of up to three words and splits the bytes into colour planes. It computes sixteen gray bytes in parallel with integer weights and hands them out as one 128-bit word. Both sides use a valid/ready handshake.

A frame length in pixels is presented with the first input word of each frame. The pixel count need not be a multiple of sixteen. The last group of a frame then takes only as many input words as its pixel bytes fill. The result word zeroes the unused lanes, and a last flag marks the final word of the frame. The weights are 6966, 23436 and 2366 and sum to 2^15. A single rounding step per pixel therefore gives bit-exact results, and full white maps to 255.

Top module: `luma_stream`

## Requirements
- R1: Each output byte equals (6966*R + 23436*G + 2366*B + 16384) >> 15 for its pixel, with the sum held in a 24-bit accumulator so nothing overflows.
- R2: Input layout: a group's byte j sits in beat j/16 at bits 8*(j%16)+7 : 8*(j%16), and pixel k of the group has red at group byte 3k, green at 3k+1 and blue at 3k+2.
- R3: Output layout: pixel k of a group appears at out_data bits 8k+7 : 8k, with pixel 0 in the lowest byte.
- R4: A pixel with R = G = B = v yields exactly v, so white (255,255,255) yields 255 and black yields 0.
- R5: The rounded value is clamped to 0..255, never wrapped; pure red, green and blue give 54, 182 and 18.
- R6: When n < 16 pixels remain in a frame, the group consumes exactly ceil(3n/16) input beats. Output lanes n..15 are zero, and input bytes beyond 3n in the last beat are ignored.
- R7: out_last is 1 on the final output word of a frame and 0 on every other word.
- R8: frame_len (pixels, at least 1) is sampled only with the first accepted beat of a frame; changes during the frame have no effect.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last stay stable. Once one completed group is held waiting behind the stalled output word, in_ready is 0: exactly six beats of a 48-pixel frame are taken during a long stall. No beat or word is lost or duplicated.
- R10: Synchronous active-high reset clears any partial group and gives out_valid = 0 and in_ready = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_len | input | 16 | Pixel count of the frame, sampled with its first beat |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat this cycle |
| in_data | input | 128 | Sixteen packed RGB bytes |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 128 | Sixteen luma bytes, pixel 0 lowest |
| out_last | output | 1 | Result word is the last of its frame |

## Verification
Two events can share a cycle: a completed group moving into the output register, and the first beat of the next group being accepted. The first can happen while the consumer drains the old output word, and the second is then accepted in that same cycle. This is provoked with back-to-back frames under always-ready, alternating-ready and sparse-ready consumers, and with frame lengths of 1, 5, 6, 10, 11 and 17 that change group size and beat count at each boundary. It is judged by recomputing every output word from the scalar formula. Misalignment of any beat corrupts the following pixels and the next frame. A final idle check catches a duplicated word, and a long initial stall checks that exactly six beats are taken.

// File: rtl/luma_pkg.sv
package luma_pkg;

    localparam int BYTE_W        = 8;
    localparam int PIX_PER_GRP   = 16;
    localparam int BEAT_BYTES    = 16;
    localparam int BEAT_W        = BEAT_BYTES * BYTE_W;
    localparam int BEATS_PER_GRP = 3;
    localparam int GRP_BYTES     = BEAT_BYTES * BEATS_PER_GRP;
    localparam int GRP_W         = GRP_BYTES * BYTE_W;
    localparam int LEN_W         = 16;
    localparam int NPIX_W        = $clog2(PIX_PER_GRP + 1);
    localparam int BCNT_W        = $clog2(BEATS_PER_GRP + 1);

    localparam int WGT_R = 6966;
    localparam int WGT_G = 23436;
    localparam int WGT_B = 2366;
    localparam int FRAC  = 15;
    localparam int ACC_W = 24;

    typedef logic [BYTE_W-1:0] pix_byte_t;

    typedef struct packed {
        pix_byte_t b;
        pix_byte_t g;
        pix_byte_t r;
    } rgb_t;

    function automatic logic [NPIX_W-1:0] grp_pixels(input logic [LEN_W-1:0] rem);
        if (rem >= LEN_W'(PIX_PER_GRP)) return NPIX_W'(PIX_PER_GRP);
        return rem[NPIX_W-1:0];
    endfunction

    function automatic logic [BCNT_W-1:0] beats_for(input logic [NPIX_W-1:0] n);
        int t;
        t = (3 * int'(n) + BEAT_BYTES - 1) / BEAT_BYTES;
        return BCNT_W'(t);
    endfunction

    function automatic pix_byte_t sat_byte(input logic [ACC_W-1:0] acc);
        logic [ACC_W-1:0] q;
        q = acc >> FRAC;
        if (q > ACC_W'(255)) return 8'hFF;
        return q[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/luma_gather.sv
module luma_gather
    import luma_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LW-1:0]     frame_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              take,
    output logic              grp_full,
    output logic              grp_last,
    output logic [NPIX_W-1:0] grp_npix,
    output logic [GRP_W-1:0]  grp_bytes
);

    logic [GRP_W-1:0]  buf_q;
    logic [BCNT_W-1:0] beat_q, need_q, beat_eff, new_need, cur_need;
    logic [NPIX_W-1:0] npix_q, new_npix;
    logic [LW-1:0]     remain_q, rem_after, rem_eff, base_rem;
    logic              busy_q, full_q, busy_eff, start_frame, acc;

    always_comb begin
        rem_after   = remain_q - LW'(npix_q);
        beat_eff    = take ? '0 : beat_q;
        busy_eff    = take ? (rem_after != '0) : busy_q;
        rem_eff     = take ? rem_after : remain_q;
        start_frame = !busy_eff;
        base_rem    = start_frame ? frame_len : rem_eff;
        new_npix    = grp_pixels(LEN_W'(base_rem));
        new_need    = beats_for(new_npix);
        cur_need    = (beat_eff == '0) ? new_need : need_q;
        in_ready    = !full_q || take;
        acc         = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q   <= 1'b0;
            busy_q   <= 1'b0;
            beat_q   <= '0;
            need_q   <= '0;
            npix_q   <= '0;
            remain_q <= '0;
        end else begin
            if (take) begin
                full_q   <= 1'b0;
                beat_q   <= '0;
                remain_q <= rem_after;
                busy_q   <= (rem_after != '0);
            end
            if (acc) begin
                buf_q[int'(beat_eff)*BEAT_W +: BEAT_W] <= in_data;
                beat_q <= beat_eff + 1'b1;
                if (beat_eff == '0) begin
                    npix_q <= new_npix;
                    need_q <= new_need;
                    if (start_frame) begin
                        remain_q <= frame_len;
                        busy_q   <= 1'b1;
                    end
                end
                if (beat_eff + 1'b1 == cur_need) full_q <= 1'b1;
            end
        end
    end

    assign grp_full  = full_q;
    assign grp_last  = (rem_after == '0);
    assign grp_npix  = npix_q;
    assign grp_bytes = buf_q;

    // R8: a held group never claims more pixels than the frame has left
    assert_group_fits_R8: assert property (@(posedge clk) disable iff (rst)
        full_q |-> (LW'(npix_q) <= remain_q && npix_q != '0));

    // R6: a group just completed has received enough bytes for its pixels
    assert_beats_cover_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> (int'(beat_q) * BEAT_BYTES >= 3 * int'(npix_q)));

endmodule

// File: rtl/luma_lane.sv
module luma_lane
    import luma_pkg::*;
(
    input  rgb_t      px,
    input  logic      en,
    output pix_byte_t y
);

    logic [ACC_W-1:0] sum;
    pix_byte_t        y_full;

    always_comb begin
        sum = ACC_W'(WGT_R) * ACC_W'(px.r)
            + ACC_W'(WGT_G) * ACC_W'(px.g)
            + ACC_W'(WGT_B) * ACC_W'(px.b)
            + ACC_W'(1 << (FRAC - 1));
        y_full = sat_byte(sum);
        y      = en ? y_full : '0;
    end

    // R4: equal channels must reproduce the channel value exactly
    always_comb begin
        if (!$isunknown(px) && px.r == px.g && px.g == px.b)
            assert_gray_identity_R4: assert (y_full == px.r);
    end

endmodule

// File: rtl/luma_emit.sv
module luma_emit
    import luma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grp_full,
    input  logic              grp_last,
    input  logic [BEAT_W-1:0] word,
    output logic              take,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last
);

    logic slot_free;

    assign slot_free = !out_valid || out_ready;
    assign take      = grp_full && slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_last  <= grp_last;
            out_data  <= word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R9: a stalled word is held unchanged
    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

// File: rtl/luma_stream.sv
module luma_stream
    import luma_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LW-1:0]     frame_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last
);

    logic              take, grp_full, grp_last;
    logic [NPIX_W-1:0] grp_npix;
    logic [GRP_W-1:0]  grp_bytes;
    logic [BEAT_W-1:0] word;

    luma_gather #(.LW(LW)) u_gather (
        .clk       (clk),
        .rst       (rst),
        .frame_len (frame_len),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .take      (take),
        .grp_full  (grp_full),
        .grp_last  (grp_last),
        .grp_npix  (grp_npix),
        .grp_bytes (grp_bytes)
    );

    for (genvar k = 0; k < PIX_PER_GRP; k++) begin : g_lane
        rgb_t px;
        assign px.r = grp_bytes[BYTE_W*(3*k)   +: BYTE_W];
        assign px.g = grp_bytes[BYTE_W*(3*k+1) +: BYTE_W];
        assign px.b = grp_bytes[BYTE_W*(3*k+2) +: BYTE_W];

        luma_lane u_lane (
            .px (px),
            .en (grp_npix > NPIX_W'(k)),
            .y  (word[BYTE_W*k +: BYTE_W])
        );
    end

    luma_emit u_emit (
        .clk       (clk),
        .rst       (rst),
        .grp_full  (grp_full),
        .grp_last  (grp_last),
        .word      (word),
        .take      (take),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: tb/luma_stream_test.sv
module luma_stream_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  frame_len = 16'd0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         out_last;

    int nchecks = 0;
    int nerr = 0;
    int beats_taken = 0;
    bit scramble = 0;

    always #5 clk = ~clk;

    luma_stream uut (
        .clk(clk), .rst(rst), .frame_len(frame_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    // {r, g, b, expected luma}
    localparam logic [31:0] PIX_TAB [6] = '{
        {8'd255, 8'd255, 8'd255, 8'd255},
        {8'd0,   8'd0,   8'd0,   8'd0},
        {8'd255, 8'd0,   8'd0,   8'd54},
        {8'd0,   8'd255, 8'd0,   8'd182},
        {8'd0,   8'd0,   8'd255, 8'd18},
        {8'd128, 8'd128, 8'd128, 8'd128}
    };

    // {frame length, seed, consumer mode}
    localparam logic [31:0] FRM_TAB [12] = '{
        {16'd16,  8'd0,  8'd0},
        {16'd32,  8'd1,  8'd0},
        {16'd1,   8'd2,  8'd1},
        {16'd5,   8'd3,  8'd0},
        {16'd6,   8'd4,  8'd2},
        {16'd10,  8'd5,  8'd1},
        {16'd11,  8'd6,  8'd0},
        {16'd17,  8'd7,  8'd2},
        {16'd48,  8'd8,  8'd3},
        {16'd21,  8'd0,  8'd1},
        {16'd64,  8'd10, 8'd2},
        {16'd100, 8'd11, 8'd0}
    };

    function automatic logic [7:0] frame_byte(input int seed, input int i);
        if (seed == 0) begin
            logic [31:0] e;
            e = PIX_TAB[(i / 3) % 6];
            return (i % 3 == 0) ? e[31:24] : (i % 3 == 1) ? e[23:16] : e[15:8];
        end
        return 8'((i * 37) + (seed * 101) + ((i * i) >> 2));
    endfunction

    function automatic logic [7:0] ref_luma(input int seed, input int p);
        int r, g, b;
        if (seed == 0) return PIX_TAB[p % 6][7:0];
        r = frame_byte(seed, 3 * p);
        g = frame_byte(seed, 3 * p + 1);
        b = frame_byte(seed, 3 * p + 2);
        return 8'((6966 * r + 23436 * g + 2366 * b + 16384) >> 15);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_beat(input logic [127:0] w);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            if (scramble) frame_len = 16'hFFFF;
            in_valid = 1'b1;
            in_data  = w;
            #2;
            if (in_ready) done = 1;
        end
        beats_taken++;
        scramble = 1;
    endtask

    task automatic drive_frame(input int len, input int seed);
        int ngrp = (len + 15) / 16;
        scramble  = 0;
        frame_len = 16'(len);
        for (int g = 0; g < ngrp; g++) begin
            int np = (len - 16 * g >= 16) ? 16 : len - 16 * g;
            int nb = (3 * np + 15) / 16;
            for (int b = 0; b < nb; b++) begin
                logic [127:0] w;
                for (int j = 0; j < 16; j++) begin
                    int ix = 16 * b + j;
                    w[8*j +: 8] = (ix < 3 * np) ? frame_byte(seed, 48 * g + ix) : 8'hA5;
                end
                send_beat(w);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        scramble = 0;
    endtask

    task automatic recv_frame(input int len, input int seed, input int mode, input int base);
        int nw = (len + 15) / 16;
        int w = 0;
        int cyc = 0;
        bit stalled = 0;
        logic [127:0] held = '0;
        if (mode == 3) begin
            out_ready = 1'b0;
            repeat (30) @(negedge clk);
            #2;
            chk(in_ready == 1'b0 && out_valid == 1'b1, "R9 stall blocks input",
                {in_ready, out_valid}, {1'b0, 1'b1});
            chk(beats_taken - base == 6, "R9 beats taken under stall",
                128'(beats_taken - base), 128'd6);
        end
        while (w < nw) begin
            @(negedge clk);
            cyc++;
            case (mode)
                1:       out_ready = cyc[0];
                2:       out_ready = (cyc % 5 == 0);
                default: out_ready = 1'b1;
            endcase
            #2;
            if (stalled)
                chk(out_valid && out_data == held, "R9 held word", out_data, held);
            if (out_valid && out_ready) begin
                logic [127:0] exp;
                for (int k = 0; k < 16; k++)
                    exp[8*k +: 8] = (16 * w + k < len) ? ref_luma(seed, 16 * w + k) : 8'h00;
                if (seed == 0)
                    chk(out_data == exp, "R4 R5 R3 table pixels", out_data, exp);
                else if (16 * w + 16 > len)
                    chk(out_data == exp, "R6 R1 partial group", out_data, exp);
                else
                    chk(out_data == exp, "R1 R2 R3 full group", out_data, exp);
                chk(out_last == (w == nw - 1), "R7 R8 last flag",
                    128'(out_last), 128'(w == nw - 1));
                w++;
                stalled = 0;
            end else begin
                stalled = out_valid;
                held    = out_data;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset state",
            {out_valid, in_ready}, {1'b0, 1'b1});

        // leave a partial group, then reset: the next frames must stay aligned
        frame_len = 16'd16;
        scramble  = 0;
        send_beat({16{8'h3C}});
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset mid group",
            {out_valid, in_ready}, {1'b0, 1'b1});

        foreach (FRM_TAB[i]) begin
            int len  = int'(FRM_TAB[i][31:16]);
            int seed = int'(FRM_TAB[i][15:8]);
            int mode = int'(FRM_TAB[i][7:0]);
            int base = beats_taken;
            fork
                drive_frame(len, seed);
                recv_frame(len, seed, mode, base);
            join
        end

        repeat (6) @(negedge clk);
        #2;
        chk(out_valid == 1'b0, "R9 no duplicated word", 128'(out_valid), 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule